// File: doc/BRIEF.md
# Two-Step Refresh Watchdog Timer

This block is a watchdog timer for a small 8-bit controller. Software reaches it through a synchronous register bus: a write strobe, a 2-bit address, 8 bits of write data, and combinational read data selected by the same address. Once software starts the watchdog, a 15-bit counter counts up from a start value taken from a 7-bit reload register. The counter advances once every 16 clocks. If it runs past its all-ones value, the block requests a system reset for one cycle, records the event in a sticky status flag, clears the reload register and stops.

To keep a program that has lost control from feeding the watchdog by accident, a refresh takes two ordered writes. Software first writes the arm bit, then writes the start bit. A start write that finds the timer running without a pending arm does nothing. Any other register write that lands between the arm and the start cancels the arm. Once started, the timer cannot be stopped by software. Only a trip or the external reset stops it.

Register map: address 0 is control, with bit 0 for arm and bit 1 for start/running. Address 1 is status, with the trip flag in bit 0. Address 2 is reload, bits 6:0. Address 3 reads as zero. The sequencer has three named states. IDLE is stopped. RUN is counting without an arm. ARMED is counting with an arm pending. The transitions are:

- START: IDLE to RUN on a start write.
- ARM: RUN to ARMED on an arm write.
- REFRESH: ARMED to RUN on a start write.
- DISARM: ARMED to RUN on any other write.
- TRIP: RUN or ARMED to IDLE on overflow.

Top module: `wdog_guard`

## Requirements
- R1: After the external reset (rst_n low), reads of addresses 0, 1, 2 and 3 all return 0, and wdt_rst_req is low.
- R2: A control write (address 0) with wr_data = 8'h02 while stopped starts the timer and loads the counter with {reload, 8'h00}. Control bit 1 then reads 1.
- R3: The counter advances once per 16 clocks. With no refresh, the trip follows 16*(32768 - 256*reload) clocks after the start or refresh write edge.
- R4: A refresh happens only when an arm write (address 0, wr_data = 8'h01) is followed by a start write (8'h02). A start write with no pending arm leaves a running count unchanged. Control writes with any of bits 7:2 set count as neither arm nor start.
- R5: Control bit 0 reads the pending arm. The arm is cleared by the refresh and by any write other than a start. An arm write while stopped is ignored.
- R6: The reload register (address 2, bits 6:0) is writable at any time and bit 7 reads 0. A new value takes effect only at the next start or refresh.
- R7: On a trip, wdt_rst_req is high for exactly one cycle, and the timer is stopped afterwards (control reads 0).
- R8: A trip sets the status flag (address 1, bit 0) and clears the reload register to 0. The trip does not clear the status flag.
- R9: A write to address 1 sets or clears the status flag from wr_data bit 0. When a trip happens in the same cycle, the trip wins.
- R10: The external reset clears the status flag and the reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External/power-on reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr, combinational |
| wdt_rst_req | output | 1 | One-cycle system reset request on a trip |

## Verification
The assertions assume that wr_en, addr and wr_data change only away from the rising clock edge. They also assume that overflow is the only source of a trip, so a reset request always coincides with a fresh trip. The bench drives every bus cycle at the falling edge. It draws random reload and status values but keeps reload starts within 0x7E and 0x7F, so each trip lands within a few thousand cycles. Arm, start and interrupting writes are placed by directed sequences, with randomised waits before each refresh.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_RUN   = 2'd1,
        WD_ARMED = 2'd2
    } wd_state_e;

    localparam logic [1:0] ADR_CTRL   = 2'd0;
    localparam logic [1:0] ADR_STATUS = 2'd1;
    localparam logic [1:0] ADR_RELOAD = 2'd2;

    localparam int CTL_ARM_BIT   = 0;
    localparam int CTL_START_BIT = 1;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr || !en) begin
            pre_q <= '0;
        end else if (pre_q == LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = en && !clr && (pre_q == LAST);
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int CNT_W = 15,
    parameter int REL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REL_W-1:0] reload,
    input  logic             step,
    output logic [CNT_W-1:0] value,
    output logic             at_max
);
    localparam int LOW_W = CNT_W - REL_W;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= {reload, {LOW_W{1'b0}}};
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign value  = cnt_q;
    assign at_max = &cnt_q;
endmodule

// File: rtl/wdog_seq_fsm.sv
module wdog_seq_fsm
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_wr,
    input  logic      arm_wr,
    input  logic      other_wr,
    input  logic      ovf,
    output wd_state_e state_o,
    output logic      load,
    output logic      trip,
    output logic      rst_req
);
    wd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        trip    = 1'b0;
        unique case (state_q)
            WD_IDLE: begin
                if (start_wr) begin          // START
                    state_d = WD_RUN;
                    load    = 1'b1;
                end
            end
            WD_RUN: begin
                if (ovf) begin               // TRIP
                    state_d = WD_IDLE;
                    trip    = 1'b1;
                end else if (arm_wr) begin   // ARM
                    state_d = WD_ARMED;
                end
            end
            WD_ARMED: begin
                if (start_wr) begin          // REFRESH
                    state_d = WD_RUN;
                    load    = 1'b1;
                end else if (ovf) begin      // TRIP
                    state_d = WD_IDLE;
                    trip    = 1'b1;
                end else if (other_wr) begin // DISARM
                    state_d = WD_RUN;
                end
            end
            default: begin
                state_d = WD_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= trip;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int REL_W  = 7,
    parameter int CNT_W  = 15,
    parameter int PRE_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              wdt_rst_req
);
    localparam int CTL_HI = DATA_W - 1;

    wd_state_e        fsm_state;
    logic [CNT_W-1:0] cnt_val;
    logic [REL_W-1:0] reload_q;
    logic             status_q;
    logic             ctrl_wr, ctrl_clean;
    logic             start_wr, arm_wr, other_wr;
    logic             load, trip, tick, at_max, ovf, running;

    assign ctrl_wr    = wr_en && (addr == ADR_CTRL);
    assign ctrl_clean = (wr_data[CTL_HI:CTL_START_BIT+1] == '0);
    assign start_wr   = ctrl_wr && ctrl_clean && wr_data[CTL_START_BIT];
    assign arm_wr     = ctrl_wr && ctrl_clean && !wr_data[CTL_START_BIT]
                        && wr_data[CTL_ARM_BIT];
    assign other_wr   = wr_en && !start_wr && !arm_wr;
    assign running    = (fsm_state != WD_IDLE);
    assign ovf        = tick && at_max;

    wdog_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_wr (start_wr),
        .arm_wr   (arm_wr),
        .other_wr (other_wr),
        .ovf      (ovf),
        .state_o  (fsm_state),
        .load     (load),
        .trip     (trip),
        .rst_req  (wdt_rst_req)
    );

    wdog_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (running),
        .clr   (load),
        .tick  (tick)
    );

    wdog_count #(.CNT_W(CNT_W), .REL_W(REL_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .reload (reload_q),
        .step   (tick),
        .value  (cnt_val),
        .at_max (at_max)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (trip) begin
            reload_q <= '0;
        end else if (wr_en && addr == ADR_RELOAD) begin
            reload_q <= wr_data[REL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (trip) begin
            status_q <= 1'b1;
        end else if (wr_en && addr == ADR_STATUS) begin
            status_q <= wr_data[0];
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            ADR_CTRL: begin
                rd_data[CTL_ARM_BIT]   = (fsm_state == WD_ARMED);
                rd_data[CTL_START_BIT] = running;
            end
            ADR_STATUS: rd_data[0] = status_q;
            ADR_RELOAD: rd_data[REL_W-1:0] = reload_q;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk
    import wdog_pkg::*;
#(
    parameter int CNT_W = 15,
    parameter int REL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_req,
    input wd_state_e        state,
    input logic [CNT_W-1:0] cnt,
    input logic             status,
    input logic [REL_W-1:0] reload,
    input logic             start_wr,
    input logic             wr_en
);
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);                                            // R7
    AST_TRIP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> state == WD_IDLE);                                    // R7
    AST_TRIP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> status);                                              // R8
    AST_TRIP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> reload == '0);                                        // R8
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state != WD_IDLE && !wr_en && !(&cnt))
        |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));             // R3
    AST_NO_UNARMED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_RUN && start_wr && !(&cnt))
        |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));             // R4
    AST_IDLE_ARM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_IDLE) |=> state != WD_ARMED);                        // R5
endmodule

bind wdog_guard wdog_guard_chk #(.CNT_W(CNT_W), .REL_W(REL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_req  (wdt_rst_req),
    .state    (fsm_state),
    .cnt      (cnt_val),
    .status   (status_q),
    .reload   (reload_q),
    .start_wr (start_wr),
    .wr_en    (wr_en)
);

// File: tb/wdog_guard_bench.sv
`timescale 1ns/1ps
module wdog_guard_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       wdt_rst_req;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_guard u_wdog_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .wdt_rst_req (wdt_rst_req)
    );

    function automatic int trip_delay(input logic [6:0] rel);
        return 16 * (32768 - 256 * int'(rel));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        #1 v = rd_data;
    endtask

    // waits for the reset request; returns cycles since mark
    task automatic wait_trip(input int mark, output int delta);
        int n = 0;
        while (!wdt_rst_req && n < 40000) begin
            @(negedge clk);
            n++;
        end
        delta = cyc - mark;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int mark, d, seed;
        seed = 32'd1234;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 read after reset", v, 0);
        end
        check("R1 rst_req after reset", wdt_rst_req, 0);

        // R6 random reload writes, bit 7 dropped; R5 arm while stopped ignored
        for (int i = 0; i < 12; i++) begin
            logic [7:0] r = 8'($urandom);
            wr(2'd2, r);
            rd(2'd2, v);
            check("R6 reload readback", v, int'(r & 8'h7F));
            wr(2'd0, 8'h01);
            rd(2'd0, v);
            check("R5 arm ignored while stopped", v, 0);
        end
        // R9 random status writes
        for (int i = 0; i < 8; i++) begin
            logic [7:0] s = 8'($urandom);
            wr(2'd1, s);
            rd(2'd1, v);
            check("R9 status write", v, int'(s[0]));
        end
        wr(2'd1, 8'h00);

        // R2 R3 start and unrefreshed trip
        wr(2'd2, 8'h7F);
        wr(2'd0, 8'h02);
        mark = cyc;
        rd(2'd0, v);
        check("R2 running after start", v, 2);
        wait_trip(mark, d);
        check("R3 trip time reload 7F", d, trip_delay(7'h7F));
        @(negedge clk);
        check("R7 request one cycle", wdt_rst_req, 0);
        rd(2'd0, v);
        check("R7 stopped after trip", v, 0);
        rd(2'd1, v);
        check("R8 status set by trip", v, 1);
        rd(2'd2, v);
        check("R8 reload cleared by trip", v, 0);
        wr(2'd1, 8'h00);
        rd(2'd1, v);
        check("R9 status cleared by software", v, 0);

        // R3 longer reload
        wr(2'd2, 8'h7E);
        wr(2'd0, 8'h02);
        mark = cyc;
        wait_trip(mark, d);
        check("R3 trip time reload 7E", d, trip_delay(7'h7E));

        // R4 start without arm does not refresh
        wr(2'd2, 8'h7F);
        wr(2'd0, 8'h02);
        mark = cyc;
        repeat (1500) @(negedge clk);
        wr(2'd0, 8'h02);
        wait_trip(mark, d);
        check("R4 unarmed start no refresh", d, trip_delay(7'h7F));

        // R4 R5 interrupted arm (status write between), and masked control write
        wr(2'd2, 8'h7F);
        wr(2'd0, 8'h02);
        mark = cyc;
        repeat (1000) @(negedge clk);
        wr(2'd0, 8'h01);
        rd(2'd0, v);
        check("R5 arm reads back", v, 3);
        wr(2'd1, 8'h00);
        rd(2'd0, v);
        check("R5 arm cleared by other write", v, 2);
        wr(2'd0, 8'h02);
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h82);
        rd(2'd0, v);
        check("R4 dirty control write cancels arm", v, 2);
        wait_trip(mark, d);
        check("R4 stale arm no refresh", d, trip_delay(7'h7F));

        // R4 R5 R6 valid refreshes with random waits, reload changed mid-run
        for (int i = 0; i < 3; i++) begin
            logic [6:0] nr = (($urandom % 2) == 0) ? 7'h7E : 7'h7F;
            wr(2'd2, 8'h7F);
            wr(2'd0, 8'h02);
            repeat (100 + ($urandom % 2900)) @(negedge clk);
            wr(2'd2, {1'b0, nr});
            wr(2'd0, 8'h01);
            wr(2'd0, 8'h02);
            mark = cyc;
            rd(2'd0, v);
            check("R5 arm cleared by refresh", v, 2);
            wait_trip(mark, d);
            check("R4 R6 trip after refresh", d, trip_delay(nr));
        end

        // R10 external reset clears status and reload
        wr(2'd2, 8'h55);
        rd(2'd1, v);
        check("R8 status retained after trip", v, 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(2'd1, v);
        check("R10 status cleared by reset", v, 0);
        rd(2'd2, v);
        check("R10 reload cleared by reset", v, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule